// File: doc/BRIEF.md
# I2C Target Address Recognizer

This block sits behind the bit-level receiver of an I2C target and decides, byte by byte, whether the node is being addressed after a START condition. The shift register delivers each completed byte with a one-cycle valid strobe. A separate one-cycle pulse marks every START or repeated START. The recognizer compares the first byte, and in 10-bit mode the second byte, against the configured addresses. When the address phase resolves to this node, it raises a single-cycle hit pulse.

Three kinds of address can select the node:
- a primary address, compared over 7 bits or over all 10 bits;
- an optional second 7-bit address;
- the general-call address 00h.

Along with the hit pulse, the block reports the transfer direction taken from bit 0 of the first byte. It also reports which kind of address produced the hit. These flags stay valid until the next START clears them. Bytes that arrive outside an address phase are ignored, so the block can watch the whole byte stream without further qualification.

Top module: `slv_addr_match`

## Requirements
- R1: After reset, `hit_pulse`, `dir_rd`, `gcall_hit` and `alt_hit` are 0, and no byte produces a hit until a `start_seen` pulse has been received.
- R2: With `fmt_10b`=0, a first byte whose bits 7:1 equal `own_addr[6:0]` raises `hit_pulse` for one cycle, in the cycle after the byte strobe, with `alt_hit`=0 and `gcall_hit`=0.
- R3: `dir_rd` takes bit 0 of the first address byte (1 = controller reads, 0 = controller writes). It is updated together with `hit_pulse`. In 10-bit mode it is taken from the header byte.
- R4: With `fmt_10b`=1, a header byte of the form 11110, then `own_addr[9:8]`, then the R/W bit gives no pulse. If the next byte equals `own_addr[7:0]`, `hit_pulse` follows that second byte. A wrong second byte gives no hit.
- R5: When `dual_en`=1, a first byte whose bits 7:1 equal `alt_addr[7:1]` produces a hit with `alt_hit`=1. When `dual_en`=0 the same byte produces no hit.
- R6: A first byte with bits 7:1 all zero produces a hit with `gcall_hit`=1 only when `gcall_en`=1. The checks are ranked in this order: general call, then primary, then second address. `gcall_hit` and `alt_hit` are never set together.
- R7: A first or second byte that matches nothing ends the address phase. Later bytes produce no hit until the next START.
- R8: A `start_seen` pulse restarts the address phase from the first byte, even in the middle of a 10-bit sequence. In the following cycle it clears `dir_rd`, `gcall_hit` and `alt_hit`. A byte strobe in the same cycle as `start_seen` is ignored.
- R9: At most one hit is produced per START. Bytes after a hit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_seen | input | 1 | One-cycle pulse on START or repeated START |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received byte, MSB first on the wire |
| own_addr | input | 10 | Primary address |
| fmt_10b | input | 1 | 1 = primary address compared over 10 bits |
| alt_addr | input | 7 | Second address, bits 7:1 of its byte position |
| dual_en | input | 1 | Enables matching against `alt_addr` |
| gcall_en | input | 1 | Enables general-call recognition |
| hit_pulse | output | 1 | One-cycle pulse: node addressed |
| dir_rd | output | 1 | Direction of the addressed transfer, 1 = read |
| gcall_hit | output | 1 | Hit was a general call |
| alt_hit | output | 1 | Hit was on the second address |

## Verification
Random configurations are paired with byte streams that are biased toward near-miss values:
- the own 7-bit address;
- a correct or wrong 10-bit header;
- the correct low byte;
- the second address;
- 00h;
- random bytes.

This mix separates full matches from matches on only part of the address. Random on/off settings of the dual-address and general-call enables, with the same bytes offered, show whether an enable really gates its match.

Directed cases cover a START that interrupts a 10-bit sequence, a START and a byte strobe in the same cycle, and a mismatching byte followed by a matching one. They also cover bytes sent without a START and bytes sent after a hit. Together these tell apart state-machine restarts, halting and single-pulse behaviour.

// File: rtl/slv_addr_pkg.sv
package slv_addr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // waiting for a START
    ST_HEAD = 2'd1,   // expecting first address byte
    ST_LOW  = 2'd2,   // expecting low byte of a 10-bit address
    ST_HALT = 2'd3    // address phase over until next START
  } sa_state_e;

  typedef struct packed {
    logic gc;      // general call recognised
    logic pri7;    // 7-bit primary match
    logic hdr10;   // 10-bit header match
    logic alt;     // second address match
  } sa_hits_t;

endpackage

// File: rtl/slv_addr_cmp.sv
module slv_addr_cmp
  import slv_addr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:1] alt_addr,
  input  logic              fmt_10b,
  input  logic              dual_en,
  input  logic              gcall_en,
  output sa_hits_t          hits,
  output logic              low_hit
);
  localparam int ADR7_W = BYTE_W - 1;
  localparam int HI_W   = ADDR_W - BYTE_W;
  localparam int TAG_W  = ADR7_W - HI_W;
  localparam logic [TAG_W-1:0] HDR_TAG = {{(TAG_W-1){1'b1}}, 1'b0};

  logic [ADR7_W-1:0] adr7;
  assign adr7 = byte_data[BYTE_W-1:1];

  always_comb begin
    hits.gc    = gcall_en && (adr7 == '0);
    hits.pri7  = !fmt_10b && (adr7 == own_addr[ADR7_W-1:0]);
    hits.hdr10 = fmt_10b &&
                 (byte_data[BYTE_W-1 -: TAG_W] == HDR_TAG) &&
                 (byte_data[HI_W:1] == own_addr[ADDR_W-1:BYTE_W]);
    hits.alt   = dual_en && (adr7 == alt_addr);
    low_hit    = (byte_data == own_addr[BYTE_W-1:0]);
  end
endmodule

// File: rtl/slv_addr_seq.sv
module slv_addr_seq
  import slv_addr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_seen,
  input  logic     byte_vld,
  input  logic     rw_bit,
  input  sa_hits_t hits,
  input  logic     low_hit,
  output logic     hit_pulse,
  output logic     dir_rd,
  output logic     gcall_hit,
  output logic     alt_hit
);
  sa_state_e st_q, st_d;
  logic pulse_d, rw_d, gc_d, alt_d, hrw_q, hrw_d;
  logic upd_en;

  assign upd_en = start_seen | byte_vld;

  always_comb begin
    st_d    = st_q;
    pulse_d = 1'b0;
    rw_d    = dir_rd;
    gc_d    = gcall_hit;
    alt_d   = alt_hit;
    hrw_d   = hrw_q;
    if (start_seen) begin
      st_d  = ST_HEAD;
      rw_d  = 1'b0;
      gc_d  = 1'b0;
      alt_d = 1'b0;
    end else if (byte_vld) begin
      unique case (st_q)
        ST_HEAD: begin
          st_d = ST_HALT;
          if (hits.gc) begin
            pulse_d = 1'b1; rw_d = rw_bit; gc_d = 1'b1;
          end else if (hits.pri7) begin
            pulse_d = 1'b1; rw_d = rw_bit;
          end else if (hits.hdr10) begin
            st_d = ST_LOW; hrw_d = rw_bit;
          end else if (hits.alt) begin
            pulse_d = 1'b1; rw_d = rw_bit; alt_d = 1'b1;
          end
        end
        ST_LOW: begin
          st_d = ST_HALT;
          if (low_hit) begin
            pulse_d = 1'b1; rw_d = hrw_q;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      hit_pulse <= 1'b0;
      dir_rd    <= 1'b0;
      gcall_hit <= 1'b0;
      alt_hit   <= 1'b0;
      hrw_q     <= 1'b0;
    end else begin
      hit_pulse <= pulse_d;
      if (upd_en) begin
        st_q      <= st_d;
        dir_rd    <= rw_d;
        gcall_hit <= gc_d;
        alt_hit   <= alt_d;
        hrw_q     <= hrw_d;
      end
    end
  end
endmodule

// File: rtl/slv_addr_match.sv
module slv_addr_match
  import slv_addr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_seen,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              fmt_10b,
  input  logic [BYTE_W-1:1] alt_addr,
  input  logic              dual_en,
  input  logic              gcall_en,
  output logic              hit_pulse,
  output logic              dir_rd,
  output logic              gcall_hit,
  output logic              alt_hit
);
  sa_hits_t hits;
  logic     low_hit;

  slv_addr_cmp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cmp (
    .byte_data (byte_data),
    .own_addr  (own_addr),
    .alt_addr  (alt_addr),
    .fmt_10b   (fmt_10b),
    .dual_en   (dual_en),
    .gcall_en  (gcall_en),
    .hits      (hits),
    .low_hit   (low_hit)
  );

  slv_addr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_seen (start_seen),
    .byte_vld   (byte_vld),
    .rw_bit     (byte_data[0]),
    .hits       (hits),
    .low_hit    (low_hit),
    .hit_pulse  (hit_pulse),
    .dir_rd     (dir_rd),
    .gcall_hit  (gcall_hit),
    .alt_hit    (alt_hit)
  );
endmodule

// File: rtl/slv_addr_match_chk.sv
module slv_addr_match_chk #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_seen,
  input logic              byte_vld,
  input logic [BYTE_W-1:0] byte_data,
  input logic              fmt_10b,
  input logic              dual_en,
  input logic              gcall_en,
  input logic              hit_pulse,
  input logic              dir_rd,
  input logic              gcall_hit,
  input logic              alt_hit
);
  // R2
  hit_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |-> $past(byte_vld) && !$past(start_seen));
  // R9
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_pulse |=> !hit_pulse);
  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> !hit_pulse && !gcall_hit && !alt_hit && !dir_rd);
  // R6
  gcall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pulse && gcall_hit) |-> $past(gcall_en) && ($past(byte_data[BYTE_W-1:1]) == '0));
  // R6
  kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gcall_hit && alt_hit));
  // R5
  alt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pulse && alt_hit) |-> $past(dual_en));
  // R3
  dir_7b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_pulse && !$past(fmt_10b)) |-> dir_rd == $past(byte_data[0]));
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_pulse && !$past(start_seen)) |-> $stable(dir_rd));
endmodule

bind slv_addr_match slv_addr_match_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/tb_slv_addr_match.sv
module tb_slv_addr_match;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_seen, byte_vld;
  logic [7:0] byte_data;
  logic [9:0] own_addr;
  logic       fmt_10b, dual_en, gcall_en;
  logic [7:1] alt_addr;
  logic       hit_pulse, dir_rd, gcall_hit, alt_hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  int m_st;      // 0 idle, 1 head, 2 low, 3 halt
  bit m_pulse, m_rw, m_gc, m_alt, m_hrw;

  always #2.5 clk = ~clk;

  slv_addr_match dut (.*);

  function automatic void model_step(bit st, bit vld, logic [7:0] d);
    m_pulse = 1'b0;
    if (st) begin
      m_st = 1; m_rw = 0; m_gc = 0; m_alt = 0;
    end else if (vld) begin
      if (m_st == 1) begin
        m_st = 3;
        if (gcall_en && d[7:1] == 7'd0) begin
          m_pulse = 1; m_rw = d[0]; m_gc = 1;
        end else if (!fmt_10b && d[7:1] == own_addr[6:0]) begin
          m_pulse = 1; m_rw = d[0];
        end else if (fmt_10b && d[7:3] == 5'b11110 && d[2:1] == own_addr[9:8]) begin
          m_st = 2; m_hrw = d[0];
        end else if (dual_en && d[7:1] == alt_addr) begin
          m_pulse = 1; m_rw = d[0]; m_alt = 1;
        end
      end else if (m_st == 2) begin
        m_st = 3;
        if (d == own_addr[7:0]) begin
          m_pulse = 1; m_rw = m_hrw;
        end
      end
    end
  endfunction

  task automatic check(string tag);
    checks++;
    if ({hit_pulse, dir_rd, gcall_hit, alt_hit} !== {m_pulse, m_rw, m_gc, m_alt}) begin
      errors++;
      $display("FAIL %s: got hit/dir/gc/alt=%b%b%b%b expected %b%b%b%b", tag,
               hit_pulse, dir_rd, gcall_hit, alt_hit, m_pulse, m_rw, m_gc, m_alt);
    end
  endtask

  task automatic step(bit st, bit vld, logic [7:0] d, string tag);
    @(negedge clk);
    start_seen = st; byte_vld = vld; byte_data = d;
    @(posedge clk);
    #1;
    model_step(st, vld, d);
    check(tag);
    @(negedge clk);
    start_seen = 0; byte_vld = 0;
  endtask

  task automatic cfg(logic [9:0] o, bit t, logic [6:0] a, bit de, bit ge);
    @(negedge clk);
    own_addr = o; fmt_10b = t; alt_addr = a; dual_en = de; gcall_en = ge;
  endtask

  function automatic logic [7:0] pick(int k);
    logic [7:0] r;
    r = 8'($urandom);
    case (k)
      0: return {own_addr[6:0], r[0]};
      1: return {5'b11110, own_addr[9:8], r[0]};
      2: return own_addr[7:0];
      3: return {alt_addr, r[0]};
      4: return {7'd0, r[0]};
      5: return {5'b11110, ~own_addr[9:8], r[0]};
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; start_seen = 0; byte_vld = 0; byte_data = 0;
    own_addr = 10'h2A5; fmt_10b = 0; alt_addr = 7'h33; dual_en = 0; gcall_en = 0;
    m_st = 0; m_pulse = 0; m_rw = 0; m_gc = 0; m_alt = 0; m_hrw = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset");
    @(negedge clk); rst_n = 1;

    // R1: byte without START ignored
    cfg(10'h025, 0, 7'h11, 1, 1);
    step(0, 1, {7'h25, 1'b1}, "R1 no start");
    // R2/R3: 7-bit read
    step(1, 0, 8'h00, "R8 start");
    step(0, 1, {7'h25, 1'b1}, "R2 R3 7bit read");
    // R9: byte after hit ignored
    step(0, 1, {7'h25, 1'b0}, "R9 after hit");
    // R8: start clears flags
    step(1, 0, 8'h00, "R8 clear");
    // R5: second address
    step(0, 1, {7'h11, 1'b0}, "R5 alt hit");
    cfg(10'h025, 0, 7'h11, 0, 1);
    step(1, 0, 8'h00, "R8 start");
    step(0, 1, {7'h11, 1'b0}, "R5 alt disabled");
    // R6: general call on / off
    step(1, 0, 8'h00, "R8 start");
    step(0, 1, 8'h00, "R6 gcall");
    cfg(10'h025, 0, 7'h11, 1, 0);
    step(1, 0, 8'h00, "R8 start");
    step(0, 1, 8'h00, "R6 gcall disabled");
    // R7: mismatch then matching byte
    step(1, 0, 8'h00, "R8 start");
    step(0, 1, 8'h55, "R7 mismatch");
    step(0, 1, {7'h25, 1'b0}, "R7 halted");
    // R4: 10-bit
    cfg(10'h2C3, 1, 7'h11, 0, 0);
    step(1, 0, 8'h00, "R8 start");
    step(0, 1, {5'b11110, 2'b10, 1'b1}, "R4 header no pulse");
    step(0, 1, 8'hC3, "R4 R3 10bit low");
    step(1, 0, 8'h00, "R8 start");
    step(0, 1, {5'b11110, 2'b10, 1'b0}, "R4 header");
    step(0, 1, 8'hC4, "R4 wrong low");
    // R8: START in middle of 10-bit
    step(1, 0, 8'h00, "R8 start");
    step(0, 1, {5'b11110, 2'b10, 1'b0}, "R4 header");
    step(1, 0, 8'h00, "R8 restart");
    step(0, 1, 8'hC3, "R8 low after restart");
    // R8: start and byte together
    cfg(10'h025, 0, 7'h11, 0, 0);
    step(1, 1, {7'h25, 1'b0}, "R8 same cycle");
    step(0, 1, {7'h25, 1'b0}, "R8 then byte");

    // random
    for (int i = 0; i < 500; i++) begin
      cfg(10'($urandom), 1'($urandom), 7'($urandom), 1'($urandom), 1'($urandom));
      if (($urandom % 8) == 0) step(0, 1, pick($urandom % 7), "R1 R7 stray byte");
      step(1, ($urandom % 10) == 0, pick($urandom % 7), "R8 random start");
      for (int j = 0; j < 1 + int'($urandom % 3); j++) begin
        int k;
        k = (j == 1 && ($urandom % 2)) ? 2 : int'($urandom % 7);
        step(0, 1, pick(k), "R2 R4 R5 R6 random byte");
        if (($urandom % 4) == 0) step(0, 0, 8'h00, "R3 hold idle");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule